// File: doc/BRIEF.md
# Pending-Bit Set/Clear Engine for Message-Signalled Interrupts

This block turns register writes aimed at a set-pending or clear-pending register into a byte-wide read-modify-write of a pending table in memory. The table holds one bit per interrupt ID. The engine takes the write strobe, the written data and a set/clear selector. It also takes three configuration inputs: the global enable for message-signalled interrupts, the ID-width field and the pending-table base. From these it computes the byte that holds the target bit, reads that byte, changes the one bit and writes the byte back.

A write is dropped without touching memory in two cases: the enable is low, or the ID lies outside the configured range. A request that would leave the bit unchanged costs one read and nothing more. That covers setting a bit that is already set and clearing a bit that is already clear. Only a real change writes memory. The engine then raises a one-cycle request that tells the priority arbiter to recompute the highest pending interrupt. One request is in flight at a time. New writes wait on a ready signal.

Top module: `lpi_pend_engine`

## Requirements
- R1: After reset, req_ready is 1 and mem_rd_req, mem_wr_req and upd_req are all 0.
- R2: While lpi_en is 0, an accepted write issues no memory read or write and no update request.
- R3: The interrupt ID is req_data[31:0]. Bits [63:32] have no effect on the ID or on the range check.
- R4: With an effective width field n, the largest valid ID is 2^(n+1)-1. A larger ID is dropped with no memory access. An ID equal to the limit is processed.
- R5: A width field above 15 is treated as 15, so the largest valid ID is 65535.
- R6: The byte address is {pend_base[51:16], 16'h0} + ID/8.
- R7: The bit position in the byte is ID%8. When req_clr is 0 the bit is set; when req_clr is 1 it is cleared. The other seven bits are written back unchanged.
- R8: A set of a bit that is already 1, or a clear of a bit that is already 0, performs the read but no write and no update request.
- R9: After a real change, upd_req is high for exactly one cycle. That cycle is the one that follows the cycle in which mem_wr_ack is sampled high.
- R10: req_ready is 0 from the cycle after acceptance until the sequence ends. A req_valid during that time is not taken.
- R11: Each accepted in-range request with lpi_en high gives a mem_rd_req pulse of exactly one cycle. While a write waits for its acknowledge, mem_wr_data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register write strobe |
| req_ready | output | 1 | Engine can accept a write |
| req_clr | input | 1 | 0 selects the set register, 1 the clear register |
| req_data | input | 64 | Written data; the ID is in bits [31:0] |
| lpi_en | input | 1 | Global enable for message-signalled interrupts |
| id_bits | input | 5 | ID-width field; largest ID is 2^(n+1)-1 |
| pend_base | input | 64 | Pending-table base; bits [51:16] are used |
| mem_rd_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 52 | Byte address for the read and the write |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_data | input | 8 | Read data byte |
| mem_wr_req | output | 1 | Byte write request, held until acknowledged |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_ack | input | 1 | Write accepted |
| upd_req | output | 1 | One-cycle request to recompute the highest pending interrupt |

## Verification
The hardest case to reach is a second register write that arrives while the first is still in its memory round trip. Such a write must be refused rather than merged or lost in a way that corrupts the table. The bench accepts one set request and keeps req_valid high with a different ID through the read and wait cycles. It drops the strobe before the engine becomes ready again. It then checks that the second ID's byte is unchanged and that exactly one write took place. The equal-to-limit and just-above-limit IDs are driven under both a small width field and an oversized one, so that the range check and the clamp are each covered.

// File: rtl/lpi_pend_pkg.sv
// Package: shared types for the pending-bit set/clear engine.
// Assumes: nothing beyond IEEE 1800-2017.
package lpi_pend_pkg;

    // Sequencer states of the read-modify-write engine.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CMP   = 3'd3,
        ST_WRITE = 3'd4,
        ST_DONE  = 3'd5
    } eng_state_t;

    // Requested bit operation.
    typedef enum logic {
        OP_SET = 1'b0,
        OP_CLR = 1'b1
    } bit_op_t;

endpackage

// File: rtl/lpi_req_filter.sv
// Module: lpi_req_filter
// Decides whether a register write is acted on, and where its bit lives.
// Assumes: the ID is the low 32 bits of the data; the width field is clamped
// to MAX_ID_BITS; the table base keeps address bits [ADDR_W-1:BASE_LO].
module lpi_req_filter #(
    parameter int DATA_W      = 64,
    parameter int ID_W        = 32,
    parameter int ADDR_W      = 52,
    parameter int BASE_LO     = 16,
    parameter int MAX_ID_BITS = 15
) (
    input  logic [DATA_W-1:0] data,
    input  logic              enable,
    input  logic [4:0]        id_bits,
    input  logic [DATA_W-1:0] base,
    output logic              take,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_idx
);
    localparam int LIM_W = ID_W + 1;

    logic [ID_W-1:0]  id;
    logic [4:0]       eff_bits;
    logic [LIM_W-1:0] largest;

    // Clamp the width field and derive the largest implemented ID.
    always_comb begin
        id       = data[ID_W-1:0];
        eff_bits = (int'(id_bits) > MAX_ID_BITS) ? 5'(MAX_ID_BITS) : id_bits;
        largest  = (LIM_W'(1) << (eff_bits + 5'd1)) - LIM_W'(1);
    end

    // Accept only while enabled and within the implemented range.
    always_comb take = enable && ({1'b0, id} <= largest);

    // Byte address: aligned base plus ID/8; bit index is ID%8.
    always_comb begin
        byte_addr = {base[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}}
                  + ADDR_W'(id[ID_W-1:3]);
        bit_idx   = id[2:0];
    end

endmodule

// File: rtl/lpi_byte_merge.sv
// Module: lpi_byte_merge
// Applies a set or clear to one bit of a byte and reports whether it changed.
// Assumes: purely combinational; the caller registers the result.
module lpi_byte_merge #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]         old_byte,
    input  logic [$clog2(BYTE_W)-1:0] idx,
    input  lpi_pend_pkg::bit_op_t     op,
    output logic [BYTE_W-1:0]         new_byte,
    output logic                      changed
);
    import lpi_pend_pkg::*;

    logic [BYTE_W-1:0] mask;

    // Build a one-hot mask for the selected bit position.
    always_comb begin
        mask = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (idx == ($clog2(BYTE_W))'(i)) mask[i] = 1'b1;
        end
    end

    // Merge the new bit value and flag a real change.
    always_comb begin
        new_byte = (op == OP_CLR) ? (old_byte & ~mask) : (old_byte | mask);
        changed  = (new_byte != old_byte);
    end

endmodule

// File: rtl/lpi_pend_engine.sv
// Module: lpi_pend_engine (top)
// Sequences idle, read, wait, compare, write, done for one set/clear request
// at a time. Pulses the arbiter update request only after a real change.
// Assumes: memory answers a one-cycle read request with one rd_valid pulse;
// a write request is held until a one-cycle acknowledge.
module lpi_pend_engine #(
    parameter int DATA_W      = 64,
    parameter int ID_W        = 32,
    parameter int ADDR_W      = 52,
    parameter int BASE_LO     = 16,
    parameter int MAX_ID_BITS = 15,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              lpi_en,
    input  logic [4:0]        id_bits,
    input  logic [DATA_W-1:0] pend_base,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd_valid,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [BYTE_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              upd_req
);
    import lpi_pend_pkg::*;

    localparam int IDX_W = $clog2(BYTE_W);

    eng_state_t        state_q;
    bit_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] rd_byte_q;
    logic [BYTE_W-1:0] wr_byte_q;

    logic              f_take;
    logic [ADDR_W-1:0] f_addr;
    logic [2:0]        f_idx;
    logic [BYTE_W-1:0] m_new;
    logic              m_changed;

    lpi_req_filter #(
        .DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W),
        .BASE_LO(BASE_LO), .MAX_ID_BITS(MAX_ID_BITS)
    ) u_filter (
        .data(req_data), .enable(lpi_en), .id_bits(id_bits),
        .base(pend_base), .take(f_take), .byte_addr(f_addr), .bit_idx(f_idx)
    );

    lpi_byte_merge #(.BYTE_W(BYTE_W)) u_merge (
        .old_byte(rd_byte_q), .idx(idx_q), .op(op_q),
        .new_byte(m_new), .changed(m_changed)
    );

    // Sequencer and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_SET;
            addr_q    <= '0;
            idx_q     <= '0;
            rd_byte_q <= '0;
            wr_byte_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid && f_take) begin
                    op_q    <= req_clr ? OP_CLR : OP_SET;
                    addr_q  <= f_addr;
                    idx_q   <= IDX_W'(f_idx);
                    state_q <= ST_READ;
                end
                ST_READ: state_q <= ST_WAIT;
                ST_WAIT: if (mem_rd_valid) begin
                    rd_byte_q <= mem_rd_data;
                    state_q   <= ST_CMP;
                end
                ST_CMP: begin
                    wr_byte_q <= m_new;
                    state_q   <= m_changed ? ST_WRITE : ST_IDLE;
                end
                ST_WRITE: if (mem_wr_ack) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_req  = (state_q == ST_READ);
        mem_wr_req  = (state_q == ST_WRITE);
        mem_addr    = addr_q;
        mem_wr_data = wr_byte_q;
        upd_req     = (state_q == ST_DONE);
    end

    // R11: the read request lasts one cycle.
    a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R11: write data is held while the acknowledge is outstanding.
    a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> $stable(mem_wr_data));

    // R9: the update request follows a sampled write acknowledge.
    a_r9_upd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> $past(mem_wr_ack));

    // R9: the update request is a single-cycle pulse.
    a_r9_upd_one: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> !upd_req);

    // R10: no new write is taken while memory work is pending.
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req || mem_rd_req) |-> !req_ready);

    // R2: a write taken while disabled starts no read.
    a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lpi_en) |=> !mem_rd_req);

    // R8: a write always changes the byte that was read.
    a_r8_real_change: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (mem_wr_data != rd_byte_q));

endmodule

// File: tb/tb_lpi_pend_engine.sv
module tb_lpi_pend_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_clr = 1'b0;
    logic [63:0] req_data = '0;
    logic        lpi_en = 1'b0;
    logic [4:0]  id_bits = 5'd15;
    logic [63:0] pend_base = 64'hFFF0_0012_3456_789A;
    logic        mem_rd_req;
    logic [51:0] mem_addr;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        mem_wr_req;
    logic [7:0]  mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        upd_req;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int upd_cnt = 0;
    int upd_bad = 0;
    logic ack_prev = 1'b0;
    logic [7:0] mem [bit [51:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpi_pend_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_clr(req_clr), .req_data(req_data), .lpi_en(lpi_en),
        .id_bits(id_bits), .pend_base(pend_base), .mem_rd_req(mem_rd_req),
        .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .upd_req(upd_req)
    );

    // Memory model: one-cycle read latency, one-cycle write acknowledge.
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_req;
        mem_rd_data  <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        mem_wr_ack   <= mem_wr_req && !mem_wr_ack;
        if (mem_wr_req && !mem_wr_ack) mem[mem_addr] = mem_wr_data;
        if (rst_n) begin
            if (mem_rd_req) rd_cnt++;
            if (mem_wr_req && !mem_wr_ack) wr_cnt++;
            if (upd_req) begin
                upd_cnt++;
                if (!ack_prev) upd_bad++;
            end
        end
        ack_prev <= mem_wr_ack;
    end

    function automatic logic [51:0] addr_of(input logic [31:0] id);
        return {pend_base[51:16], 16'h0} + 52'(id >> 3);
    endfunction

    function automatic logic [7:0] peek(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit clr, input logic [63:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_clr   = clr;
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready", longint'(req_ready), 1);
        check(mem_rd_req == 1'b0, "R1 rd_req", longint'(mem_rd_req), 0);
        check(mem_wr_req == 1'b0, "R1 wr_req", longint'(mem_wr_req), 0);
        check(upd_req == 1'b0, "R1 upd", longint'(upd_req), 0);
    endtask

    task automatic t_set_basic();
        int w0 = wr_cnt; int u0 = upd_cnt;
        logic [51:0] a = addr_of(32'h2005);
        check(a == 52'h0012_3456_0400, "R6 addr calc", longint'(a), 64'h0012_3456_0400);
        issue(1'b0, 64'h2005);
        check(peek(a) == 8'h20, "R6 R7 set bit5", longint'(peek(a)), 8'h20);
        check(wr_cnt == w0 + 1, "R7 one write", wr_cnt - w0, 1);
        check(upd_cnt == u0 + 1, "R9 one update", upd_cnt - u0, 1);
    endtask

    task automatic t_clear_keep();
        logic [51:0] a = addr_of(32'h11);
        mem[a] = 8'hFF;
        issue(1'b1, 64'h11);
        check(peek(a) == 8'hFD, "R7 clear bit1 keep rest", longint'(peek(a)), 8'hFD);
    endtask

    task automatic t_redundant();
        int r0 = rd_cnt; int w0 = wr_cnt; int u0 = upd_cnt;
        logic [51:0] a = addr_of(32'h2005);
        issue(1'b0, 64'h2005);
        issue(1'b1, 64'h2006);
        check(rd_cnt == r0 + 2, "R8 reads done", rd_cnt - r0, 2);
        check(wr_cnt == w0, "R8 no write", wr_cnt - w0, 0);
        check(upd_cnt == u0, "R8 no update", upd_cnt - u0, 0);
        check(peek(a) == 8'h20, "R8 byte kept", longint'(peek(a)), 8'h20);
    endtask

    task automatic t_disabled();
        int r0 = rd_cnt;
        logic [51:0] a = addr_of(32'h40);
        lpi_en = 1'b0;
        issue(1'b0, 64'h40);
        lpi_en = 1'b1;
        check(rd_cnt == r0, "R2 no read when disabled", rd_cnt - r0, 0);
        check(peek(a) == 8'h00, "R2 byte untouched", longint'(peek(a)), 0);
    endtask

    task automatic t_upper_bits();
        logic [51:0] a = addr_of(32'h100);
        issue(1'b0, 64'hDEAD_BEEF_0000_0100);
        check(peek(a) == 8'h01, "R3 upper bits ignored", longint'(peek(a)), 1);
    endtask

    task automatic t_range();
        int r0;
        id_bits = 5'd3;
        r0 = rd_cnt;
        issue(1'b0, 64'd16);
        check(rd_cnt == r0, "R4 id above limit dropped", rd_cnt - r0, 0);
        issue(1'b0, 64'd15);
        check(peek(addr_of(32'd15)) == 8'h80, "R4 id at limit set",
              longint'(peek(addr_of(32'd15))), 8'h80);
        id_bits = 5'd31;
        r0 = rd_cnt;
        issue(1'b0, 64'd65536);
        check(rd_cnt == r0, "R5 clamp drops 65536", rd_cnt - r0, 0);
        issue(1'b0, 64'd65535);
        check(peek(addr_of(32'd65535)) == 8'h80, "R5 clamp keeps 65535",
              longint'(peek(addr_of(32'd65535))), 8'h80);
        id_bits = 5'd15;
    endtask

    task automatic t_busy();
        int w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_clr = 1'b0; req_data = 64'h300;
        @(negedge clk);
        check(req_ready == 1'b0, "R10 busy after accept", longint'(req_ready), 0);
        req_data = 64'h508;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(peek(addr_of(32'h300)) == 8'h01, "R10 first done",
              longint'(peek(addr_of(32'h300))), 1);
        check(peek(addr_of(32'h508)) == 8'h00, "R10 second refused",
              longint'(peek(addr_of(32'h508))), 0);
        check(wr_cnt == w0 + 1, "R10 single write", wr_cnt - w0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        lpi_en = 1'b1;
        t_set_basic();
        t_clear_keep();
        t_redundant();
        t_disabled();
        t_upper_bits();
        t_range();
        t_busy();
        check(upd_bad == 0, "R9 update only after ack", upd_bad, 0);
        check(rd_cnt > 0, "R11 reads issued", rd_cnt, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule